// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block holds M words of N bits and answers the question "which stored words look like this argument?" in one step. A search presents an argument word together with a per-bit key. Only the bit positions where the key is 1 take part in the comparison, so a key of all ones asks for an exact match. A key of all zeros matches every occupied word. Every stored word is compared in parallel, and the outcome is captured in an M-bit match vector with one bit per word.

After a search the block streams the matching words out, one per cycle, lowest index first. Each beat presents the word's index and contents and retires that bit from the match vector. When the vector is empty, a one-cycle done pulse follows.

Each word carries an occupancy bit. An insert places its data in the lowest-index free word, and a full flag reports when no word is free. A clear input empties the whole store and abandons any read-out in progress.

Top module: `mask_cam`

## Requirements
- R1: While reset is held and on the cycle after it is released, `match_vec` is 0, `rd_valid` and `rd_done` are 0, and `full` is 0.
- R2: Search data is sampled at the edge where `srch_valid` is 1. From the next cycle, bit i of `match_vec` is 1 exactly when word i is occupied and `((stored_i ^ srch_arg) & srch_key) == 0`. A key bit of 0 removes that position from the comparison, and an all-ones key compares the whole word.
- R3: An unoccupied word never matches, whatever its old contents and whatever the key, including an all-zero key.
- R4: While `rd_valid` is 1, `rd_index` is the lowest set bit of `match_vec` and `rd_data` is the word stored there. On the following cycle that bit is 0 and the other bits are unchanged. The beats begin in the cycle right after the search.
- R5: `rd_done` is 1 for exactly one cycle, in the cycle after the last beat, or in the first cycle after the search if nothing matched. After that cycle, `rd_valid` and `rd_done` stay 0 until the next search.
- R6: An insert writes `ins_data` into the lowest-index unoccupied word and marks it occupied. Any search sampled on a later edge sees the new word.
- R7: `full` is 1 exactly when every word is occupied. An insert while `full` is 1 changes no word and leaves `full` at 1.
- R8: `clear` takes precedence over insert and search in the same cycle. On the next cycle every word is unoccupied, `match_vec` is 0, `full` is 0, and no read-out is in progress.
- R9: A search issued during a read-out replaces the match vector and restarts the read-out from the new result.
- R10: A search and an insert sampled on the same edge compare against the contents that existed before that insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Empty the store and stop any read-out |
| ins_valid | input | 1 | Insert request |
| ins_data | input | N | Word to insert |
| srch_valid | input | 1 | Search request |
| srch_arg | input | N | Argument word to look for |
| srch_key | input | N | Per-bit compare enable (1 = compare) |
| match_vec | output | M | Registered match vector; bits retire during read-out |
| rd_valid | output | 1 | A matching word is presented this cycle |
| rd_index | output | $clog2(M) | Index of the presented word |
| rd_data | output | N | Contents of the presented word |
| rd_done | output | 1 | One-cycle pulse: read-out finished |
| full | output | 1 | Every word is occupied |

## Verification
The match vector is due one edge after the search request is sampled. The first read-out beat is due in that same cycle, and each later beat follows one cycle after the one before it. `rd_done` comes one cycle after the last beat, and insert or clear effects appear one edge after the request. The bench drives every input on the falling edge and samples at the next falling edge. It then walks the read-out beat by beat in ascending order of the indices its own model predicts, so each check lands in the exact cycle the result is due. The expected vectors come from a bench-side model of the words and their occupancy bits, with the masked comparison applied to each word.

// File: rtl/mcam_pkg.sv
// Package: shared definitions for the masked content-addressable memory.
// Assumes: nothing beyond standard SystemVerilog.
package mcam_pkg;

    // Width of an index into a set of `count` elements (at least 1 bit).
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/mcam_first_one.sv
// Module: mcam_first_one
// Finds the lowest-index set bit of a vector and reports whether any bit is set.
// Assumes: IW is wide enough to hold W-1.
module mcam_first_one #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top down so that the lowest set bit is the last one written.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    // Any bit set.
    assign found = |vec;

endmodule

// File: rtl/mcam_store.sv
// Module: mcam_store
// Holds M words with occupancy bits, compares all of them against a masked argument
// in parallel, and gives one read port by index.
// Assumes: wr_idx points at a free word whenever wr_en is 1; clear outranks wr_en.
module mcam_store #(
    parameter int N  = 8,
    parameter int M  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [N-1:0]  wr_data,
    input  logic [N-1:0]  arg,
    input  logic [N-1:0]  key,
    output logic [M-1:0]  hit_vec,
    output logic [M-1:0]  active,
    input  logic [IW-1:0] rd_idx,
    output logic [N-1:0]  rd_word
);

    logic [N-1:0] words [M];

    // Word storage and occupancy: reset and clear free every slot; a write fills one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
            for (int i = 0; i < M; i++) words[i] <= '0;
        end else if (clear) begin
            active <= '0;
        end else if (wr_en) begin
            words[wr_idx]  <= wr_data;
            active[wr_idx] <= 1'b1;
        end
    end

    // One masked comparator per word; a free word never hits.
    for (genvar g = 0; g < M; g++) begin : g_cmp
        assign hit_vec[g] = active[g] & ~|((words[g] ^ arg) & key);
    end

    // Read port for the read-out stage.
    assign rd_word = words[rd_idx];

endmodule

// File: rtl/mask_cam.sv
// Module: mask_cam (top)
// Masked content-addressable memory: parallel masked search into a registered match
// vector, lowest-index-first read-out of the matches, insert into the first free word,
// and a store-wide clear.
// Assumes: synchronous active-low reset; clear has priority over search and insert.
module mask_cam
    import mcam_pkg::*;
#(
    parameter int N = 8,
    parameter int M = 8,
    localparam int IW = idx_width(M)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          ins_valid,
    input  logic [N-1:0]  ins_data,
    input  logic          srch_valid,
    input  logic [N-1:0]  srch_arg,
    input  logic [N-1:0]  srch_key,
    output logic [M-1:0]  match_vec,
    output logic          rd_valid,
    output logic [IW-1:0] rd_index,
    output logic [N-1:0]  rd_data,
    output logic          rd_done,
    output logic          full
);

    logic [M-1:0]  hit_vec;
    logic [M-1:0]  active;
    logic          free_found;
    logic [IW-1:0] free_idx;
    logic          lo_found;
    logic [IW-1:0] lo_idx;
    logic          wr_en;
    logic [M-1:0]  match_q;
    logic          busy_q;

    // Lowest free slot for inserts.
    mcam_first_one #(.W(M), .IW(IW)) u_free (
        .vec   (~active),
        .found (free_found),
        .idx   (free_idx)
    );

    // Lowest pending match for read-out.
    mcam_first_one #(.W(M), .IW(IW)) u_lo (
        .vec   (match_q),
        .found (lo_found),
        .idx   (lo_idx)
    );

    // An insert proceeds only when a free slot exists and no clear is pending.
    assign wr_en = ins_valid & free_found & ~clear;

    mcam_store #(.N(N), .M(M), .IW(IW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .wr_en   (wr_en),
        .wr_idx  (free_idx),
        .wr_data (ins_data),
        .arg     (srch_arg),
        .key     (srch_key),
        .hit_vec (hit_vec),
        .active  (active),
        .rd_idx  (lo_idx),
        .rd_word (rd_data)
    );

    // Match register and read-out sequencing: load on search, retire lowest bit per beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            match_q <= '0;
            busy_q  <= 1'b0;
        end else if (srch_valid) begin
            match_q <= hit_vec;
            busy_q  <= 1'b1;
        end else if (busy_q) begin
            if (lo_found) match_q <= match_q & (match_q - M'(1));
            else          busy_q  <= 1'b0;
        end
    end

    assign match_vec = match_q;
    assign rd_valid  = busy_q & lo_found;
    assign rd_index  = lo_idx;
    assign rd_done   = busy_q & ~lo_found;
    assign full      = ~free_found;

endmodule

// File: rtl/mask_cam_sva.sv
// Module: mask_cam_sva
// Checker for mask_cam, bound to every instance; observes ports only.
// Assumes: the same parameters as the bound instance.
module mask_cam_sva #(
    parameter int N  = 8,
    parameter int M  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          srch_valid,
    input logic          ins_valid,
    input logic [M-1:0]  match_vec,
    input logic          rd_valid,
    input logic [IW-1:0] rd_index,
    input logic          rd_done,
    input logic          full
);

    // Held reset leaves outputs idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (match_vec == '0 && !rd_valid && !rd_done && !full));

    // Presented index is the lowest pending match.
    p_rd_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (match_vec[rd_index] &&
                      ((match_vec & ((M'(1) << rd_index) - M'(1))) == '0)));

    // Each beat retires exactly the presented bit.
    p_rd_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !srch_valid && !clear) |=>
            (match_vec == ($past(match_vec) & ~(M'(1) << $past(rd_index)))));

    // Done never coincides with a beat.
    p_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_done));

    // Done lasts one cycle and the stream stays quiet afterwards.
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !srch_valid && !clear) |=> (!rd_done && !rd_valid));

    // Full persists until clear.
    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clear) |=> full);

    // Insert into a full store keeps it full.
    p_full_insert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ins_valid && !clear) |=> full);

    // Clear empties everything next cycle.
    p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (match_vec == '0 && !full && !rd_valid && !rd_done));

endmodule

bind mask_cam mask_cam_sva #(.N(N), .M(M), .IW(IW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .srch_valid (srch_valid),
    .ins_valid  (ins_valid),
    .match_vec  (match_vec),
    .rd_valid   (rd_valid),
    .rd_index   (rd_index),
    .rd_done    (rd_done),
    .full       (full)
);

// File: tb/mask_cam_bench.sv
// Directed bench for mask_cam: one task per scenario, each checking its own results
// against a bench-side model of words and occupancy bits.
module mask_cam_bench;

    localparam int N  = 8;
    localparam int M  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          ins_valid = 1'b0;
    logic [N-1:0]  ins_data = '0;
    logic          srch_valid = 1'b0;
    logic [N-1:0]  srch_arg = '0;
    logic [N-1:0]  srch_key = '0;
    logic [M-1:0]  match_vec;
    logic          rd_valid;
    logic [IW-1:0] rd_index;
    logic [N-1:0]  rd_data;
    logic          rd_done;
    logic          full;

    int n_chk = 0;
    int n_bad = 0;

    logic [N-1:0] mdl_w [M];
    logic [M-1:0] mdl_act = '0;

    mask_cam #(.N(N), .M(M)) u_mask_cam (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .ins_valid(ins_valid), .ins_data(ins_data),
        .srch_valid(srch_valid), .srch_arg(srch_arg), .srch_key(srch_key),
        .match_vec(match_vec), .rd_valid(rd_valid), .rd_index(rd_index),
        .rd_data(rd_data), .rd_done(rd_done), .full(full)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [M-1:0] mdl_hits(input logic [N-1:0] a, input logic [N-1:0] k);
        logic [M-1:0] v;
        for (int i = 0; i < M; i++) v[i] = mdl_act[i] && (((mdl_w[i] ^ a) & k) == '0);
        return v;
    endfunction

    // Model the effect of one accepted insert.
    task automatic mdl_insert(input logic [N-1:0] d);
        for (int i = 0; i < M; i++) begin
            if (!mdl_act[i]) begin
                mdl_w[i] = d;
                mdl_act[i] = 1'b1;
                return;
            end
        end
    endtask

    // Walk read-out of an expected vector starting at the current negedge (R4, R5).
    task automatic drain(input logic [M-1:0] ev);
        for (int i = 0; i < M; i++) begin
            if (ev[i]) begin
                chk(rd_valid == 1'b1, "R4 beat valid", 32'(rd_valid), 1);
                chk(rd_index == IW'(i), "R4 beat index", 32'(rd_index), 32'(i));
                chk(rd_data == mdl_w[i], "R4 beat data", 32'(rd_data), 32'(mdl_w[i]));
                @(negedge clk);
            end
        end
        chk(rd_done == 1'b1 && rd_valid == 1'b0, "R5 done pulse", {rd_done, rd_valid}, 32'h2);
        @(negedge clk);
        chk(rd_done == 1'b0 && rd_valid == 1'b0, "R5 quiet after done", {rd_done, rd_valid}, 0);
    endtask

    task automatic run_search(input logic [N-1:0] a, input logic [N-1:0] k);
        logic [M-1:0] ev;
        ev = mdl_hits(a, k);
        @(negedge clk);
        srch_valid = 1'b1; srch_arg = a; srch_key = k;
        @(negedge clk);
        srch_valid = 1'b0;
        chk(match_vec == ev, "R2 match vector", 32'(match_vec), 32'(ev));
        drain(ev);
    endtask

    task automatic run_insert(input logic [N-1:0] d);
        @(negedge clk);
        ins_valid = 1'b1; ins_data = d;
        @(negedge clk);
        ins_valid = 1'b0;
        if (!(&mdl_act)) mdl_insert(d);
        chk(full == (&mdl_act), "R7 full flag", 32'(full), 32'(&mdl_act));
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(match_vec == '0 && !rd_valid && !rd_done && !full, "R1 reset state",
            {match_vec, rd_valid, rd_done, full}, 0);
    endtask

    // Empty store: all-zero key finds nothing, done at once (R3, R5).
    task automatic t_empty;
        run_search('0, '0);
    endtask

    // Partial fill then exact and wildcard searches (R3, R6).
    task automatic t_partial;
        for (int i = 0; i < 3; i++) run_insert({4'(i), ((i % 2) != 0) ? 4'hA : 4'h5});
        run_search('0, '0);                // only occupied words: R3
        run_search(8'h1A, 8'hFF);          // exact: R2
    endtask

    // Fill and masked searches over fields (R2, R4, R6, R7).
    task automatic t_fill_masked;
        for (int i = 3; i < M; i++) run_insert({4'(i), ((i % 2) != 0) ? 4'hA : 4'h5});
        chk(full == 1'b1, "R7 full after fill", 32'(full), 1);
        run_search(8'h0A, 8'h0F);          // low field only: odd indices
        run_search(8'h30, 8'hF0);          // high field only
        run_search(8'h3A, 8'hFF);          // whole word
        run_search(8'h3A, 8'hFE);          // one bit excluded
        run_search(8'h00, 8'h00);          // all occupied words
    endtask

    // Insert while full changes nothing (R7).
    task automatic t_full_insert;
        run_insert(8'hEE);
        chk(full == 1'b1, "R7 full holds", 32'(full), 1);
        run_search(8'hEE, 8'hFF);          // rejected word absent
        run_search(8'h25, 8'hFF);          // old word intact
    endtask

    // New search mid read-out restarts (R9).
    task automatic t_restart;
        logic [M-1:0] ev;
        @(negedge clk);
        srch_valid = 1'b1; srch_arg = '0; srch_key = '0;
        @(negedge clk);
        srch_valid = 1'b0;
        chk(rd_index == 0 && rd_valid, "R4 first beat", 32'(rd_index), 0);
        @(negedge clk);
        chk(rd_index == 1 && rd_valid, "R4 second beat", 32'(rd_index), 1);
        ev = mdl_hits(8'h50, 8'hF0);
        srch_valid = 1'b1; srch_arg = 8'h50; srch_key = 8'hF0;
        @(negedge clk);
        srch_valid = 1'b0;
        chk(match_vec == ev, "R9 restart vector", 32'(match_vec), 32'(ev));
        drain(ev);
    endtask

    // Clear beats simultaneous insert and search (R8, R3).
    task automatic t_clear;
        @(negedge clk);
        clear = 1'b1; ins_valid = 1'b1; ins_data = 8'h77;
        srch_valid = 1'b1; srch_arg = '0; srch_key = '0;
        @(negedge clk);
        clear = 1'b0; ins_valid = 1'b0; srch_valid = 1'b0;
        mdl_act = '0;
        chk(match_vec == '0 && !full && !rd_valid && !rd_done, "R8 clear state",
            {match_vec, full, rd_valid, rd_done}, 0);
        run_search('0, '0);                // R3: stale words never match
    endtask

    // Refill order and same-edge search/insert (R6, R10).
    task automatic t_same_edge;
        logic [M-1:0] ev;
        run_insert(8'hC1);
        run_insert(8'hC2);
        run_search(8'hC0, 8'hF0);          // R6: slots 0 and 1
        ev = mdl_hits(8'h99, 8'hFF);       // before insert: no hit
        @(negedge clk);
        ins_valid = 1'b1; ins_data = 8'h99;
        srch_valid = 1'b1; srch_arg = 8'h99; srch_key = 8'hFF;
        @(negedge clk);
        ins_valid = 1'b0; srch_valid = 1'b0;
        mdl_insert(8'h99);
        chk(match_vec == ev, "R10 pre-insert compare", 32'(match_vec), 32'(ev));
        drain(ev);
        run_search(8'h99, 8'hFF);          // R6: now at slot 2
    endtask

    initial begin
        for (int i = 0; i < M; i++) mdl_w[i] = '0;
        t_reset;
        t_empty;
        t_partial;
        t_fill_masked;
        t_full_insert;
        t_restart;
        t_clear;
        t_same_edge;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule